// File: doc/BRIEF.md
# Bridge PWM Output Steering Unit

This unit builds one pulse-width-modulated waveform with 10-bit duty resolution. An 8-bit period counter is extended by a 2-bit sub-step that counts 0 to 3, so each step of the period register is four clocks long. The unit then routes that waveform onto four output pins, A to D. Four routings are available: a single modulated pin, a complementary half-bridge pair with programmable dead time, and an H-bridge driven in the forward or the reverse direction. Two polarity bits choose active-high or active-low levels for each pin pair. The pair A/C is one pair and the pair B/D is the other.

Next to each pin the unit reports an ownership flag. When the flag is 1, the unit drives the pin. When it is 0, the pin belongs to general-purpose port logic, and the unit drives a level of 0 on it. The waveform runs only while the two-bit mode input is `11`. Any other mode releases all four pins and holds the counter at the start of a period.

Period and duty values are sampled at period boundaries, so a change made in the middle of a period never produces a runt pulse. The pin and ownership outputs are registered. They show the state of the cycle before the clock edge.

Top module: `bridge_pwm_steer`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `pin` and `pin_own` read 0000.
- R2: When `mode_hi` is not `11`, the next edge sets `pin_own` and `pin` to 0000. While the mode stays disabled, the position counter is held at zero and `period` and `duty` are sampled on every edge. The first enabled cycle starts a new period.
- R3: The position is {step counter, sub-step}, where the sub-step counts 0 to 3. After the position with step equal to the sampled period P and sub-step 3, the position wraps to 0. A period therefore lasts 4·(P+1) clocks. The raw waveform is active while the position is less than the sampled duty, and the pins show it one clock later.
- R4: A duty of 0 keeps the raw waveform inactive for the whole period. A duty of at least 4·(P+1) keeps it active for the whole period.
- R5: Changes to `period` and `duty` made during an enabled period take effect only at the following wrap.
- R6: With `bridge_cfg`=00, only pin A (bit 0) is owned, and it carries the waveform.
- R7: With `bridge_cfg`=01, all pins are owned. Pin D (bit 3) carries the waveform, pin A is held active, and pins B and C are held inactive.
- R8: With `bridge_cfg`=10, pins A and B are owned and pins C and D are released. A is active when the waveform is active, and B is active when the waveform is inactive. Each of them turns on only after its condition has held for `dead` clocks, and the two are never active in the same cycle.
- R9: With `bridge_cfg`=11, all pins are owned. Pin B carries the waveform, pin C is held active, and pins A and D are held inactive.
- R10: `pol_sel[1]`=1 makes pins A and C active-low. `pol_sel[0]`=1 makes pins B and D active-low. Released pins ignore polarity and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_hi | input | 2 | Waveform enabled when `11` |
| period | input | 8 | Period register P |
| duty | input | 10 | Duty value, compared with {step, sub-step} |
| bridge_cfg | input | 2 | Routing: 00 single, 01 forward, 10 half-bridge, 11 reverse |
| pol_sel | input | 2 | Bit 1: A/C active-low; bit 0: B/D active-low |
| dead | input | 7 | Dead time in clocks for the half-bridge |
| pin | output | 4 | Pin levels; bit 0 is A, bit 3 is D |
| pin_own | output | 4 | 1 when the unit drives the pin |

## Verification
The assertions assume that `mode_hi` and `period` are sampled synchronously. They also assume that any input may change on any cycle. The checks on latched values therefore hold only for the timing of the sampled copies, not for the inputs themselves. The stimulus changes inputs only on the falling clock edge. It also makes deliberate mid-period changes to duty and period, so the boundary sampling and the dead-time counters are exercised against the reference model.

// File: rtl/bridge_pwm_steer.sv
module bridge_pwm_steer #(
  parameter int PER_W  = 8,
  parameter int FRAC_W = 2,
  parameter int DB_W   = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_hi,
  input  logic [PER_W-1:0]        period,
  input  logic [PER_W+FRAC_W-1:0] duty,
  input  logic [1:0]              bridge_cfg,
  input  logic [1:0]              pol_sel,
  input  logic [DB_W-1:0]         dead,
  output logic [3:0]              pin,
  output logic [3:0]              pin_own
);

  localparam int POS_W = PER_W + FRAC_W;
  localparam logic [FRAC_W-1:0] FRAC_LAST = '1;
  localparam logic [DB_W-1:0]   RUN_SAT   = '1;

  logic [PER_W-1:0]  step_q, per_q;
  logic [FRAC_W-1:0] sub_q;
  logic [POS_W-1:0]  duty_q;
  logic [DB_W-1:0]   run_a, run_b;
  logic [3:0]        act_q;

  wire en       = (mode_hi == 2'b11);
  wire [POS_W-1:0] pos = {step_q, sub_q};
  wire at_end   = (sub_q == FRAC_LAST) && (step_q == per_q);
  wire raw      = en && (pos < duty_q);
  wire side_a   = raw && (run_a >= dead);
  wire side_b   = en && !raw && (run_b >= dead);
  wire [3:0] flip = {pol_sel[0], pol_sel[1], pol_sel[0], pol_sel[1]};

  logic [3:0] act_d, own_d;

  always_comb begin
    act_d = 4'b0000;
    own_d = 4'b0000;
    if (en) begin
      unique case (bridge_cfg)
        2'b00: begin own_d = 4'b0001; act_d = {3'b000, raw}; end
        2'b01: begin own_d = 4'b1111; act_d = {raw, 2'b00, 1'b1}; end
        2'b10: begin own_d = 4'b0011; act_d = {2'b00, side_b, side_a}; end
        default: begin own_d = 4'b1111; act_d = {1'b0, 1'b1, raw, 1'b0}; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      sub_q   <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      run_a   <= '0;
      run_b   <= '0;
      act_q   <= '0;
      pin_own <= '0;
      pin     <= '0;
    end else begin
      act_q   <= act_d;
      pin_own <= own_d;
      pin     <= own_d & (act_d ^ flip);
      run_a   <= raw ? ((run_a == RUN_SAT) ? run_a : run_a + 1'b1) : '0;
      run_b   <= (en && !raw) ? ((run_b == RUN_SAT) ? run_b : run_b + 1'b1) : '0;
      if (!en || at_end) begin
        step_q <= '0;
        sub_q  <= '0;
        per_q  <= period;
        duty_q <= duty;
      end else if (sub_q == FRAC_LAST) begin
        step_q <= step_q + 1'b1;
        sub_q  <= '0;
      end else begin
        sub_q  <= sub_q + 1'b1;
      end
    end
  end

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_q[0] && act_q[1]));

  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi != 2'b11) |=> (pin_own == 4'b0000 && pin == 4'b0000));

  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= per_q);

  a_r5_hold_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !at_end) |=> ($stable(per_q) && $stable(duty_q)));

  a_r7_forward_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bridge_cfg == 2'b01) |=> (act_q[0] && !act_q[1] && !act_q[2]));

endmodule

// File: tb/test_bridge_pwm_steer.sv
module test_bridge_pwm_steer;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode_hi = 0, bridge_cfg = 0, pol_sel = 0;
  logic [7:0] period = 0;
  logic [9:0] duty = 0;
  logic [6:0] dead = 0;
  logic [3:0] pin, pin_own;

  bridge_pwm_steer i_bridge_pwm_steer (.clk(clk), .rst_n(rst_n), .mode_hi(mode_hi),
    .period(period), .duty(duty), .bridge_cfg(bridge_cfg), .pol_sel(pol_sel),
    .dead(dead), .pin(pin), .pin_own(pin_own));

  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  int m_pos = 0, m_per = 0, m_duty = 0, m_ra = 0, m_rb = 0;
  logic [3:0] m_pin = 0, m_own = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_per = 0; m_duty = 0; m_ra = 0; m_rb = 0;
      m_pin = 0; m_own = 0;
    end else begin
      bit en, raw, a, b;
      logic [3:0] act, own, inv;
      en  = (mode_hi == 2'b11);
      raw = en && (m_pos < m_duty);
      a   = raw && (m_ra >= int'(dead));
      b   = en && !raw && (m_rb >= int'(dead));
      act = 0; own = 0;
      if (en) begin
        if (bridge_cfg == 0) begin own = 4'b0001; act[0] = raw; end
        else if (bridge_cfg == 1) begin own = 4'b1111; act[0] = 1; act[3] = raw; end
        else if (bridge_cfg == 2) begin own = 4'b0011; act[0] = a; act[1] = b; end
        else begin own = 4'b1111; act[2] = 1; act[1] = raw; end
      end
      inv = {pol_sel[0], pol_sel[1], pol_sel[0], pol_sel[1]};
      m_own = own;
      m_pin = own & (act ^ inv);
      m_ra = raw ? ((m_ra < 127) ? m_ra + 1 : 127) : 0;
      m_rb = (en && !raw) ? ((m_rb < 127) ? m_rb + 1 : 127) : 0;
      if (!en || m_pos == m_per * 4 + 3) begin
        m_pos = 0; m_per = int'(period); m_duty = int'(duty);
      end else m_pos = m_pos + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      total++;
      if (pin !== m_pin || pin_own !== m_own) begin
        bad++;
        $display("FAIL %s pin=%b own=%b expected pin=%b own=%b", tag, pin, pin_own, m_pin, m_own);
      end
      if (cycles > 150000) begin
        bad++;
        $display("FAIL watchdog expired in %s", tag);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    run(4);
    rst_n = 1;
    run(3);
    tag = "R2"; mode_hi = 2'b10; bridge_cfg = 1; period = 3; duty = 5;
    run(20);
    tag = "R6"; mode_hi = 2'b11; bridge_cfg = 0; period = 4; duty = 7;
    run(60);
    tag = "R3"; period = 2; duty = 3;
    run(50);
    tag = "R4"; duty = 0;
    run(40);
    tag = "R4"; duty = 1023;
    run(40);
    tag = "R4"; duty = 12;
    run(40);
    tag = "R5"; period = 6; duty = 9;
    run(7);
    duty = 20; run(5); period = 1; run(3); duty = 2;
    run(60);
    tag = "R2"; mode_hi = 2'b01; run(6); mode_hi = 2'b11; run(30);
    tag = "R7"; bridge_cfg = 1; period = 5; duty = 10;
    run(50);
    tag = "R9"; bridge_cfg = 3;
    run(50);
    tag = "R8"; bridge_cfg = 2; dead = 0; period = 4; duty = 8;
    run(60);
    tag = "R8"; dead = 3;
    run(60);
    tag = "R8"; dead = 30; duty = 17;
    run(80);
    tag = "R8"; dead = 127; period = 255; duty = 600;
    run(2100);
    tag = "R10";
    period = 3; duty = 6; dead = 2;
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 4; p++) begin
        bridge_cfg = c[1:0]; pol_sel = p[1:0];
        run(24);
      end
    end
    tag = "R10"; mode_hi = 2'b00; pol_sel = 2'b11;
    run(10);
    tag = "R1"; rst_n = 0; mode_hi = 2'b11;
    run(3);
    rst_n = 1;
    run(10);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule